// File: doc/BRIEF.md
# Serial GPIO LED Shift Engine

This block drives enclosure status LEDs for a set of drive ports over a three-wire serial link made of a serial clock, a load strobe and a data line. It keeps three LED bits for every port (activity, locate, fault) in a packed pattern register. A remap table gives each port its own three-bit slot in that pattern. Each accepted update request rewrites one port's slot and then sends the whole pattern to the remote LED controller as one frame.

A frame has four parts in this order: a programmable run of leading clocks with the load line low, one clock with the load line high, the data bits sent least-significant first, and a programmable run of trailing clocks. A tick divider sets the length of each half of a serial clock period. Requests enter through a valid/ready stream port backed by a one-deep holding register. The sender may keep `req_valid` high and hold its payload while `req_ready` is low. The transfer completes in the cycle where both are high. `req_ready` is high exactly when the holding register is empty. While a frame is on the wire, one further request can be accepted and waits there. It is applied and sent as the next frame.

Top module: `led_serial_shifter`

## Requirements
- R1: After reset, `sg_clk`, `sg_load` and `sg_data` are low, `busy` is low, `req_ready` is high and every pattern bit is zero.
- R2: A port's LED bits go to pattern bits 3×slot+0 (activity), 3×slot+1 (locate) and 3×slot+2 (fault). The slot is the field at bits [3p+2:3p] of `cfg_slot_map` for port p. Slots belonging to other ports keep their values.
- R3: Within `req_state`, activity is set when bit 0 or bit 1 is 1, locate equals bit 2, and fault equals bit 3. Each LED bit is cleared when its request bit or bits are 0.
- R4: A frame consists of `cfg_pre` clocks with load low, then exactly one clock with load high, then 3×`cfg_nports` data clocks, then `cfg_post` clocks. A count of zero leaves that part out.
- R5: Data bits leave least-significant bit first, one per serial clock, sampled at its rising edge. `sg_data` is low during the leading, load and trailing clocks.
- R6: Each serial clock period starts with a low half and ends with a high half, and each half lasts `cfg_half`+1 cycles of `clk`.
- R7: `sg_data` and `sg_load` change only while `sg_clk` is low, so both are stable across every rising edge.
- R8: A request with `req_port` ≥ `cfg_nports` is consumed but rejected. It leaves the pattern unchanged and sends no frame.
- R9: `busy` is high from the start of a frame until its last clock ends. While `busy` is low, all three link lines are low.
- R10: `req_ready` equals the emptiness of the holding register. A request accepted during a frame is held, with `req_ready` low, and is sent as the next frame once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Holding register empty, request will be taken |
| req_port | input | PORT_W (4) | Port index of the request |
| req_state | input | 4 | LED request bits: [1:0] activity, [2] locate, [3] fault |
| cfg_half | input | DIV_W (16) | Half-period length minus one, in `clk` cycles |
| cfg_pre | input | CNT_W (4) | Leading clock count |
| cfg_post | input | CNT_W (4) | Trailing clock count |
| cfg_nports | input | PORT_W (4) | Number of ports in a frame (1..NUM_PORTS) |
| cfg_slot_map | input | NUM_PORTS×SLOT_W (24) | Slot of each port, 3 bits per port |
| busy | output | 1 | Frame in progress |
| sg_clk | output | 1 | Serial clock |
| sg_load | output | 1 | Load strobe |
| sg_data | output | 1 | Serial data |

## Verification
The assertions assume that the configuration inputs stay constant while `busy` is high, that `cfg_nports` lies between 1 and NUM_PORTS, and that every slot in the map is below `cfg_nports`. The stimulus changes configuration only after the bench's expected-frame queue has drained and `busy` has fallen. It chooses slot maps that are permutations of the active slots, so each assumption holds by construction of the sequence. The sweeps cover every port with every request code and rotate through divider, leading and trailing counts. They also cover a shortened port count with rejected indices and a request queued behind a running frame.

// File: rtl/led_sg_pkg.sv
package led_sg_pkg;

  localparam int REQ_W = 4;
  localparam int ACT_A_BIT = 0;
  localparam int ACT_B_BIT = 1;
  localparam int LOC_BIT   = 2;
  localparam int FLT_BIT   = 3;

  // three LED bits of one slot; activity sits at the lowest position
  typedef struct packed {
    logic fault;
    logic locate;
    logic active;
  } led_bits_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_LOAD,
    SQ_DATA,
    SQ_POST
  } seq_state_e;

  function automatic led_bits_t decode_req(input logic [REQ_W-1:0] st);
    led_bits_t b;
    b.active = st[ACT_A_BIT] | st[ACT_B_BIT];
    b.locate = st[LOC_BIT];
    b.fault  = st[FLT_BIT];
    return b;
  endfunction

endpackage

// File: rtl/led_pattern_reg.sv
module led_pattern_reg
  import led_sg_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 4,
  parameter int SLOT_W    = 3,
  localparam int PAT_W    = 3 * NUM_PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_en,
  input  logic [PORT_W-1:0]           upd_port,
  input  led_bits_t                   upd_bits,
  input  logic [NUM_PORTS*SLOT_W-1:0] slot_map,
  output logic [PAT_W-1:0]            pattern
);

  logic [SLOT_W-1:0] tgt_slot;

  // look the port up in the remap table
  always_comb begin
    tgt_slot = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (upd_port == PORT_W'(p)) tgt_slot = slot_map[p*SLOT_W +: SLOT_W];
    end
  end

  for (genvar s = 0; s < NUM_PORTS; s++) begin : g_slot
    logic [2:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (upd_en && tgt_slot == SLOT_W'(s)) begin
        slot_q <= upd_bits;
      end
    end
    assign pattern[3*s +: 3] = slot_q;
  end

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
  import led_sg_pkg::*;
#(
  parameter int PAT_W  = 24,
  parameter int PORT_W = 4,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 4,
  localparam int BITS_W = $clog2(PAT_W + 1),
  localparam int CYC_W  = (CNT_W > BITS_W) ? CNT_W : BITS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAT_W-1:0]  pattern,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [CNT_W-1:0]  cfg_post,
  input  logic [PORT_W-1:0] cfg_nports,
  output logic              busy,
  output logic              sg_clk,
  output logic              sg_load,
  output logic              sg_data
);

  seq_state_e        st_q;
  logic [DIV_W-1:0]  tick_q;
  logic              hi_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [CYC_W-1:0]  cyc_nx;
  logic [CYC_W-1:0]  nbits;
  logic [PAT_W-1:0]  shreg_q;
  logic              half_end;

  assign cyc_nx   = cyc_q + CYC_W'(1);
  assign nbits    = CYC_W'(cfg_nports) * CYC_W'(3);
  assign half_end = (tick_q == cfg_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      tick_q  <= '0;
      hi_q    <= 1'b0;
      cyc_q   <= '0;
      shreg_q <= '0;
    end else if (st_q == SQ_IDLE) begin
      if (start) begin
        st_q    <= (cfg_pre != '0) ? SQ_PRE : SQ_LOAD;
        shreg_q <= pattern;
        tick_q  <= '0;
        hi_q    <= 1'b0;
        cyc_q   <= '0;
      end
    end else if (!half_end) begin
      tick_q <= tick_q + DIV_W'(1);
    end else begin
      tick_q <= '0;
      if (!hi_q) begin
        hi_q <= 1'b1;
      end else begin
        // end of a serial clock period: step to the next one
        hi_q <= 1'b0;
        unique case (st_q)
          SQ_PRE: begin
            if (cyc_nx == CYC_W'(cfg_pre)) begin
              st_q  <= SQ_LOAD;
              cyc_q <= '0;
            end else begin
              cyc_q <= cyc_nx;
            end
          end
          SQ_LOAD: begin
            st_q  <= SQ_DATA;
            cyc_q <= '0;
          end
          SQ_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (cyc_nx == nbits) begin
              st_q  <= (cfg_post != '0) ? SQ_POST : SQ_IDLE;
              cyc_q <= '0;
            end else begin
              cyc_q <= cyc_nx;
            end
          end
          SQ_POST: begin
            if (cyc_nx == CYC_W'(cfg_post)) begin
              st_q  <= SQ_IDLE;
              cyc_q <= '0;
            end else begin
              cyc_q <= cyc_nx;
            end
          end
          default: st_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign sg_clk  = hi_q;
  assign sg_load = (st_q == SQ_LOAD);
  assign sg_data = (st_q == SQ_DATA) & shreg_q[0];

endmodule

// File: rtl/led_serial_shifter.sv
module led_serial_shifter
  import led_sg_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DIV_W     = 16,
  parameter int CNT_W     = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS + 1),
  localparam int SLOT_W   = $clog2((NUM_PORTS > 1) ? NUM_PORTS : 2),
  localparam int PAT_W    = 3 * NUM_PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [PORT_W-1:0]           req_port,
  input  logic [REQ_W-1:0]            req_state,
  input  logic [DIV_W-1:0]            cfg_half,
  input  logic [CNT_W-1:0]            cfg_pre,
  input  logic [CNT_W-1:0]            cfg_post,
  input  logic [PORT_W-1:0]           cfg_nports,
  input  logic [NUM_PORTS*SLOT_W-1:0] cfg_slot_map,
  output logic                        busy,
  output logic                        sg_clk,
  output logic                        sg_load,
  output logic                        sg_data
);

  logic              hold_v_q;
  logic [PORT_W-1:0] hold_port_q;
  logic [REQ_W-1:0]  hold_state_q;
  logic              kick_q;
  logic              seq_busy;
  logic              apply;
  logic              in_range;
  logic [PAT_W-1:0]  pattern;

  assign req_ready = !hold_v_q;
  assign apply     = hold_v_q && !seq_busy && !kick_q;
  assign in_range  = (hold_port_q < cfg_nports) && (hold_port_q < PORT_W'(NUM_PORTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v_q     <= 1'b0;
      hold_port_q  <= '0;
      hold_state_q <= '0;
      kick_q       <= 1'b0;
    end else begin
      kick_q <= apply && in_range;
      if (apply) begin
        hold_v_q <= 1'b0;
      end else if (req_valid && req_ready) begin
        hold_v_q     <= 1'b1;
        hold_port_q  <= req_port;
        hold_state_q <= req_state;
      end
    end
  end

  led_pattern_reg #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .SLOT_W    (SLOT_W)
  ) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (apply && in_range),
    .upd_port (hold_port_q),
    .upd_bits (decode_req(hold_state_q)),
    .slot_map (cfg_slot_map),
    .pattern  (pattern)
  );

  led_frame_seq #(
    .PAT_W  (PAT_W),
    .PORT_W (PORT_W),
    .DIV_W  (DIV_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (kick_q),
    .pattern    (pattern),
    .cfg_half   (cfg_half),
    .cfg_pre    (cfg_pre),
    .cfg_post   (cfg_post),
    .cfg_nports (cfg_nports),
    .busy       (seq_busy),
    .sg_clk     (sg_clk),
    .sg_load    (sg_load),
    .sg_data    (sg_data)
  );

  assign busy = seq_busy | kick_q;

endmodule

// File: rtl/led_serial_shifter_chk.sv
module led_serial_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic sg_clk,
  input logic sg_load,
  input logic sg_data
);

  // R7
  data_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sg_data) |-> !sg_clk);

  // R7
  load_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sg_load) |-> !sg_clk);

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sg_clk && !sg_load && !sg_data));

  // R5
  load_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sg_load |-> !sg_data);

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

endmodule

bind led_serial_shifter led_serial_shifter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .sg_clk    (sg_clk),
  .sg_load   (sg_load),
  .sg_data   (sg_data)
);

// File: tb/led_serial_shifter_test.sv
module led_serial_shifter_test;

  localparam int NP  = 8;
  localparam int PW  = 4;
  localparam int SW  = 3;
  localparam int PAT = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_port = '0;
  logic [3:0]    req_state = '0;
  logic [15:0]   cfg_half = '0;
  logic [3:0]    cfg_pre = '0;
  logic [3:0]    cfg_post = '0;
  logic [PW-1:0] cfg_nports = 4'(NP);
  logic [NP*SW-1:0] cfg_slot_map = '0;
  logic          busy, sg_clk, sg_load, sg_data;

  always #10 clk = ~clk;

  led_serial_shifter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_state(req_state), .cfg_half(cfg_half),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_nports(cfg_nports),
    .cfg_slot_map(cfg_slot_map), .busy(busy), .sg_clk(sg_clk),
    .sg_load(sg_load), .sg_data(sg_data)
  );

  typedef struct packed {
    logic [PAT-1:0] pat;
    logic [7:0]     pre;
    logic [7:0]     post;
    logic [7:0]     half;
    logic [7:0]     n;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int map_a[NP];
  logic [PAT-1:0] model_pat = '0;

  bit mon_load[128];
  bit mon_data[128];
  int nrise = 0;
  int last_rise = 0;
  int frames_seen = 0;
  bit timing_bad = 0, glitch_bad = 0;
  bit prev_clk = 0, prev_busy = 0, prev_load = 0, prev_data = 0;

  function automatic void chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endfunction

  function automatic void check_frame();
    exp_t e;
    int total, loads, extra;
    logic [PAT-1:0] got, mask;
    frames_seen++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R8 unexpected frame", nrise, 0);
      return;
    end
    e = exp_q.pop_front();
    total = int'(e.pre) + 1 + 3 * int'(e.n) + int'(e.post);
    chk(nrise == total, "R4 serial clock count", nrise, total);
    loads = 0;
    extra = 0;
    got = '0;
    for (int i = 0; i < nrise && i < 128; i++) begin
      if (mon_load[i]) loads++;
      if (i > int'(e.pre) && i <= int'(e.pre) + 3 * int'(e.n)) begin
        got[i - int'(e.pre) - 1] = mon_data[i];
      end else if (mon_data[i]) begin
        extra++;
      end
    end
    chk(loads == 1 && mon_load[e.pre], "R4 single load clock position", loads, 1);
    mask = (PAT'(1) << (3 * int'(e.n))) - PAT'(1);
    if (int'(e.n) == NP) mask = '1;
    chk(got == (e.pat & mask), "R2 R3 R5 shifted pattern", int'(got), int'(e.pat & mask));
    chk(extra == 0, "R5 data low outside data bits", extra, 0);
    chk(!timing_bad, "R6 half period length", int'(timing_bad), 0);
    chk(!glitch_bad, "R7 data/load stable while clock high", int'(glitch_bad), 0);
    chk(!sg_clk && !sg_load && !sg_data, "R9 idle lines low",
        int'({sg_clk, sg_load, sg_data}), 0);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        nrise = 0;
        timing_bad = 0;
        glitch_bad = 0;
      end
      if (sg_clk && !prev_clk) begin
        if (nrise > 0 && cyc - last_rise != 2 * (int'(cfg_half) + 1)) timing_bad = 1;
        if (nrise < 128) begin
          mon_load[nrise] = sg_load;
          mon_data[nrise] = sg_data;
        end
        nrise++;
        last_rise = cyc;
      end
      if (!sg_clk && prev_clk && cyc - last_rise != int'(cfg_half) + 1) timing_bad = 1;
      if (sg_clk && prev_clk && (sg_data != prev_data || sg_load != prev_load)) glitch_bad = 1;
      if (!busy && prev_busy) check_frame();
    end
    prev_clk  = sg_clk;
    prev_busy = busy;
    prev_load = sg_load;
    prev_data = sg_data;
  end

  task automatic set_map();
    for (int p = 0; p < NP; p++) cfg_slot_map[p*SW +: SW] = SW'(map_a[p]);
  endtask

  // expected pattern from R2/R3, and frame if the port is in range (R8)
  task automatic model(input int port, input int st);
    exp_t e;
    int s;
    if (port < int'(cfg_nports)) begin
      s = map_a[port];
      model_pat[3*s]     = st[0] | st[1];
      model_pat[3*s + 1] = st[2];
      model_pat[3*s + 2] = st[3];
      e.pat  = model_pat;
      e.pre  = 8'(cfg_pre);
      e.post = 8'(cfg_post);
      e.half = 8'(cfg_half);
      e.n    = 8'(cfg_nports);
      exp_q.push_back(e);
    end
  endtask

  task automatic send(input int port, input int st);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_port  = PW'(port);
    req_state = 4'(st);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !busy && req_ready) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int fr0;
    for (int p = 0; p < NP; p++) map_a[p] = (3 * p + 1) % NP;
    set_map();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(!sg_clk && !sg_load && !sg_data, "R1 lines low after reset",
        int'({sg_clk, sg_load, sg_data}), 0);
    chk(!busy && req_ready, "R1 busy low ready high", int'({busy, req_ready}), 1);

    // sweep: every port with every request code (R1 via first frame, R2-R7, R9)
    for (int p = 0; p < NP; p++) begin
      for (int st = 0; st < 16; st++) begin
        wait_idle();
        cfg_half = 16'(p % 3);
        cfg_pre  = 4'(st % 3);
        cfg_post = 4'((p + st) % 3);
        model(p, st);
        send(p, st);
      end
    end
    wait_idle();

    // R10: request queued behind a running frame
    cfg_half = 16'd1;
    cfg_pre  = 4'd1;
    cfg_post = 4'd1;
    model(2, 4'b1001);
    send(2, 4'b1001);
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    model(5, 4'b0110);
    send(5, 4'b0110);
    chk(!req_ready, "R10 ready low while holding", int'(req_ready), 0);
    wait_idle();
    chk(frames_seen == 130, "R10 both frames sent", frames_seen, 130);

    // R8: shortened port count, out-of-range requests rejected
    cfg_nports = 4'd4;
    for (int p = 0; p < NP; p++) map_a[p] = (p < 4) ? 3 - p : 0;
    set_map();
    cfg_pre = 4'd0;
    cfg_post = 4'd2;
    cfg_half = 16'd0;
    fr0 = frames_seen;
    send(6, 4'b1111);
    send(4, 4'b1111);
    repeat (200) @(negedge clk);
    chk(frames_seen == fr0 && !busy, "R8 no frame for rejected port", frames_seen - fr0, 0);
    chk(req_ready, "R8 rejected request consumed", int'(req_ready), 1);
    model(1, 4'b0100);
    send(1, 4'b0100);
    wait_idle();
    model(3, 4'b0001);
    send(3, 4'b0001);
    wait_idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule